// File: doc/BRIEF.md
# Settable 24-Hour Time-of-Day Clock

This block keeps the time of day as three pairs of BCD digits (hours, minutes, seconds) and drives a multiplexed seven-segment display with eight digit positions. Everything runs on one system clock. Divider counters make single-cycle enable strobes for the one-second count, a fast auto-repeat rate for setting, a digit-scan rate and a key-sampling rate. No derived or gated clocks are used.

Three active-low push keys set the time. Holding the hour key steps the hours at the repeat rate, and holding the minute key steps the minutes the same way. Each field wraps within its own range and passes no carry upward. Holding the seconds key keeps the seconds at 00. Each key passes through a two-flop synchronizer and a two-sample press filter. A key-enable input turns the three key functions on or off. The display shows hours, a dash, minutes, a dash and seconds, one digit position at a time.

Top module: `wallclock_core`

## Requirements
- R1: While the synchronous active-high reset is asserted, the time reads 00:00:00 and the first digit position (hour tens, `dig_n` = 8'hFE) is selected.
- R2: Seconds count in BCD from 00 to 59 and advance by one on each count tick. After 59 they return to 00.
- R3: When the seconds wrap from 59 to 00 on a tick and the minute key is not held, the minutes advance by one, from 00 to 59 in BCD.
- R4: Hours count from 00 to 23 in BCD and are advanced by the minute wrap. 23:59:59 is followed by 00:00:00.
- R5: While the hour key is held, the hours step once per repeat strobe and wrap from 23 to 00. The minutes are not changed by this.
- R6: While the minute key is held, the minutes step once per repeat strobe and wrap from 59 to 00. The hours do not advance, and a seconds wrap in this time is ignored.
- R7: While the seconds key is held, the seconds stay at 00. After the key is released, counting resumes.
- R8: A key counts as held only after its synchronized input reads low on two consecutive sample strobes. A high sample releases it at once. A low pulse that at most one sample can see has no effect.
- R9: While `key_en` is low, all three keys are ignored.
- R10: Exactly one bit of `dig_n` is low. The selected position advances by one on each scan strobe, cycling 0 to 7 (bit i low selects position i).
- R11: Positions 0 to 7 show hour tens, hour units, dash, minute tens, minute units, dash, second tens, second units. Segments are active high in bit order g..a: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1100111, dash=1000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| key_en | input | 1 | High enables the three set keys |
| hr_key_n | input | 1 | Hour advance key, active low |
| min_key_n | input | 1 | Minute advance key, active low |
| sec_key_n | input | 1 | Seconds clear key, active low |
| hr_bcd | output | 8 | Hours, tens in [7:4], units in [3:0] |
| min_bcd | output | 8 | Minutes, tens in [7:4], units in [3:0] |
| sec_bcd | output | 8 | Seconds, tens in [7:4], units in [3:0] |
| seg | output | 7 | Segment drive g..a, active high |
| dig_n | output | 8 | Digit select, active low, one-hot |

## Verification
The properties assume that each key input is a plain level: it may change at any cycle, and the synchronizer absorbs metastability. The properties also assume that the parameters give every strobe divider an exact whole ratio of at least two. The bench scales the clock rates down so that a tick is 40 cycles, a repeat step 20, a key sample 4 and a scan step 2. It changes inputs only on falling edges and holds or releases keys for many sample periods. The one exception is the deliberate two-cycle glitch, which at most one sample can catch.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

   typedef struct packed {
      logic [3:0] tens;
      logic [3:0] units;
   } bcd2_t;

   typedef enum logic [1:0] {
      KF_IDLE = 2'd0,
      KF_ONE  = 2'd1,
      KF_HELD = 2'd2
   } kf_state_t;

   localparam logic [6:0] SEG_DASH = 7'b1000000;

   // segment pattern, bit 6 = g ... bit 0 = a
   function automatic logic [6:0] seg_code(input logic [3:0] d);
      logic [6:0] s;
      case (d)
         4'd0:    s = 7'b0111111;
         4'd1:    s = 7'b0000110;
         4'd2:    s = 7'b1011011;
         4'd3:    s = 7'b1001111;
         4'd4:    s = 7'b1100110;
         4'd5:    s = 7'b1101101;
         4'd6:    s = 7'b1111101;
         4'd7:    s = 7'b0000111;
         4'd8:    s = 7'b1111111;
         4'd9:    s = 7'b1100111;
         default: s = 7'b0000000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/wclk_strobe.sv
module wclk_strobe #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst,
   output logic pulse
);
   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("wclk_strobe: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign pulse = (cnt == LAST);
endmodule

// File: rtl/wclk_keyflt.sv
module wclk_keyflt
   import wclk_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic sample,
   input  logic key_n,
   output logic held
);
   logic [1:0] sync_q;
   kf_state_t  st;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= 2'b11;
      else     sync_q <= {sync_q[0], key_n};
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         st <= KF_IDLE;
      end else if (sample) begin
         if (sync_q[1])          st <= KF_IDLE;
         else if (st == KF_IDLE) st <= KF_ONE;
         else                    st <= KF_HELD;
      end
   end

   assign held = (st == KF_HELD);
endmodule

// File: rtl/wclk_bcd_field.sv
module wclk_bcd_field
   import wclk_pkg::*;
#(
   parameter logic [7:0] LAST = 8'h59
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       step,
   output logic [7:0] val
);
   if (LAST[3:0] > 4'd9 || LAST[7:4] > 4'd9) begin : g_bad_last
      $error("wclk_bcd_field: LAST must be two BCD digits");
   end

   bcd2_t q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         q <= '0;
      end else if (step) begin
         if (q == LAST) begin
            q <= '0;
         end else if (q.units == 4'd9) begin
            q.units <= 4'd0;
            q.tens  <= q.tens + 4'd1;
         end else begin
            q.units <= q.units + 4'd1;
         end
      end
   end

   assign val = q;
endmodule

// File: rtl/wclk_scan.sv
module wclk_scan
   import wclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       step,
   input  logic [7:0] hr,
   input  logic [7:0] mn,
   input  logic [7:0] sc,
   output logic [6:0] seg,
   output logic [7:0] dig_n
);
   logic [2:0] pos;
   logic [3:0] digit;
   logic       dash;

   always_ff @(posedge clk) begin
      if (rst)       pos <= '0;
      else if (step) pos <= pos + 3'd1;
   end

   always_comb begin
      dash  = 1'b0;
      digit = 4'd0;
      case (pos)
         3'd0: digit = hr[7:4];
         3'd1: digit = hr[3:0];
         3'd2: dash  = 1'b1;
         3'd3: digit = mn[7:4];
         3'd4: digit = mn[3:0];
         3'd5: dash  = 1'b1;
         3'd6: digit = sc[7:4];
         default: digit = sc[3:0];
      endcase
   end

   assign seg   = dash ? SEG_DASH : seg_code(digit);
   assign dig_n = ~(8'd1 << pos);
endmodule

// File: rtl/wallclock_core.sv
module wallclock_core #(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned TICK_HZ   = 1,
   parameter int unsigned REPEAT_HZ = 10,
   parameter int unsigned SCAN_HZ   = 1000,
   parameter int unsigned SAMPLE_HZ = 200
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       key_en,
   input  logic       hr_key_n,
   input  logic       min_key_n,
   input  logic       sec_key_n,
   output logic [7:0] hr_bcd,
   output logic [7:0] min_bcd,
   output logic [7:0] sec_bcd,
   output logic [6:0] seg,
   output logic [7:0] dig_n
);
   localparam int N_STB   = 4;
   localparam int ST_TICK = 0;
   localparam int ST_REP  = 1;
   localparam int ST_SCAN = 2;
   localparam int ST_SAMP = 3;
   localparam int unsigned RATE [N_STB] = '{TICK_HZ, REPEAT_HZ, SCAN_HZ, SAMPLE_HZ};
   localparam int N_KEY = 3;

   logic [N_STB-1:0] stb;
   logic [N_KEY-1:0] keys_n, held;

   for (genvar g = 0; g < N_STB; g++) begin : g_stb
      if (RATE[g] == 0 || CLK_HZ % RATE[g] != 0) begin : g_bad_rate
         $error("wallclock_core: every rate must divide CLK_HZ exactly");
      end
      wclk_strobe #(.DIV(CLK_HZ / RATE[g])) u_div (
         .clk(clk), .rst(rst), .pulse(stb[g])
      );
   end

   assign keys_n = {sec_key_n, min_key_n, hr_key_n};

   for (genvar k = 0; k < N_KEY; k++) begin : g_key
      wclk_keyflt u_flt (
         .clk(clk), .rst(rst), .en(key_en), .sample(stb[ST_SAMP]),
         .key_n(keys_n[k]), .held(held[k])
      );
   end

   logic hr_adj, min_adj, sec_clr;
   logic sec_step, sec_carry, min_step, min_carry, hr_step;

   assign hr_adj  = held[0];
   assign min_adj = held[1];
   assign sec_clr = held[2];

   assign sec_step  = stb[ST_TICK];
   assign sec_carry = sec_step && !sec_clr && (sec_bcd == 8'h59);
   assign min_step  = min_adj ? stb[ST_REP] : sec_carry;
   assign min_carry = !min_adj && sec_carry && (min_bcd == 8'h59);
   assign hr_step   = hr_adj ? stb[ST_REP] : min_carry;

   wclk_bcd_field #(.LAST(8'h59)) u_sec (
      .clk(clk), .rst(rst), .clr(sec_clr), .step(sec_step), .val(sec_bcd)
   );
   wclk_bcd_field #(.LAST(8'h59)) u_min (
      .clk(clk), .rst(rst), .clr(1'b0), .step(min_step), .val(min_bcd)
   );
   wclk_bcd_field #(.LAST(8'h23)) u_hr (
      .clk(clk), .rst(rst), .clr(1'b0), .step(hr_step), .val(hr_bcd)
   );

   wclk_scan u_scan (
      .clk(clk), .rst(rst), .step(stb[ST_SCAN]),
      .hr(hr_bcd), .mn(min_bcd), .sc(sec_bcd),
      .seg(seg), .dig_n(dig_n)
   );
endmodule

// File: rtl/wallclock_core_chk.sv
module wallclock_core_chk (
   input logic       clk,
   input logic       rst,
   input logic       sec_clr,
   input logic       sec_step,
   input logic       min_adj,
   input logic       hr_adj,
   input logic [7:0] hr_bcd,
   input logic [7:0] min_bcd,
   input logic [7:0] sec_bcd,
   input logic [6:0] seg,
   input logic [7:0] dig_n
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (hr_bcd == 8'h00 && min_bcd == 8'h00 && sec_bcd == 8'h00 && dig_n == 8'hFE));

   // R2
   sec_range_chk: assert property (@(posedge clk) disable iff (rst)
      sec_bcd[7:4] <= 4'd5 && sec_bcd[3:0] <= 4'd9);

   // R2
   sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!sec_step && !sec_clr) |=> $stable(sec_bcd));

   // R3
   min_range_chk: assert property (@(posedge clk) disable iff (rst)
      min_bcd[7:4] <= 4'd5 && min_bcd[3:0] <= 4'd9);

   // R4
   hr_range_chk: assert property (@(posedge clk) disable iff (rst)
      hr_bcd <= 8'h23 && hr_bcd[3:0] <= 4'd9);

   // R6
   hr_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (min_adj && !hr_adj) |=> $stable(hr_bcd));

   // R7
   sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
      sec_clr |=> sec_bcd == 8'h00);

   // R10
   one_digit_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(~dig_n) == 1);

   // R11
   dash_chk: assert property (@(posedge clk) disable iff (rst)
      (dig_n == 8'hFB || dig_n == 8'hDF) |-> seg == 7'b1000000);
endmodule

bind wallclock_core wallclock_core_chk u_chk (
   .clk(clk), .rst(rst), .sec_clr(sec_clr), .sec_step(sec_step),
   .min_adj(min_adj), .hr_adj(hr_adj), .hr_bcd(hr_bcd), .min_bcd(min_bcd),
   .sec_bcd(sec_bcd), .seg(seg), .dig_n(dig_n)
);

// File: tb/wallclock_core_bench.sv
module wallclock_core_bench;
   // scaled rates: tick = 40 cycles, repeat = 20, scan = 2, sample = 4
   localparam int unsigned CLK_HZ = 400;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       key_en = 1'b1;
   logic       hr_key_n = 1'b1, min_key_n = 1'b1, sec_key_n = 1'b1;
   logic [7:0] hr_bcd, min_bcd, sec_bcd, dig_n;
   logic [6:0] seg;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wallclock_core #(
      .CLK_HZ(CLK_HZ), .TICK_HZ(10), .REPEAT_HZ(20), .SCAN_HZ(200), .SAMPLE_HZ(100)
   ) u_wallclock_core (
      .clk(clk), .rst(rst), .key_en(key_en),
      .hr_key_n(hr_key_n), .min_key_n(min_key_n), .sec_key_n(sec_key_n),
      .hr_bcd(hr_bcd), .min_bcd(min_bcd), .sec_bcd(sec_bcd),
      .seg(seg), .dig_n(dig_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [6:0] exp_seg(input logic [3:0] d);
      case (d)
         4'd0: return 7'b0111111;
         4'd1: return 7'b0000110;
         4'd2: return 7'b1011011;
         4'd3: return 7'b1001111;
         4'd4: return 7'b1100110;
         4'd5: return 7'b1101101;
         4'd6: return 7'b1111101;
         4'd7: return 7'b0000111;
         4'd8: return 7'b1111111;
         4'd9: return 7'b1100111;
         default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [7:0] field(input int sel);
      case (sel)
         0: return hr_bcd;
         1: return min_bcd;
         default: return sec_bcd;
      endcase
   endfunction

   task automatic press(input int sel, input logic lvl);
      case (sel)
         0: hr_key_n = lvl;
         1: min_key_n = lvl;
         default: sec_key_n = lvl;
      endcase
   endtask

   task automatic hold_until(input int sel, input logic [7:0] target, input string tag);
      press(sel, 1'b0);
      for (int i = 0; i < 3000 && field(sel) != target; i++) @(negedge clk);
      press(sel, 1'b1);
      cyc(20);
      chk(field(sel) == target, tag, field(sel), target);
   endtask

   task automatic clear_sec();
      sec_key_n = 1'b0;
      cyc(20);
      sec_key_n = 1'b1;
      cyc(8);
   endtask

   // R1
   task automatic t_reset();
      rst = 1'b1;
      cyc(3);
      chk(hr_bcd == 8'h00, "R1 hours", hr_bcd, 8'h00);
      chk(min_bcd == 8'h00, "R1 minutes", min_bcd, 8'h00);
      chk(sec_bcd == 8'h00, "R1 seconds", sec_bcd, 8'h00);
      chk(dig_n == 8'hFE, "R1 digit select", dig_n, 8'hFE);
      rst = 1'b0;
   endtask

   // R2, R3
   task automatic t_count();
      cyc(220);
      chk(sec_bcd == 8'h05, "R2 five ticks", sec_bcd, 8'h05);
      for (int i = 0; i < 3000 && min_bcd != 8'h01; i++) @(negedge clk);
      chk(min_bcd == 8'h01, "R3 minute carry", min_bcd, 8'h01);
      chk(sec_bcd == 8'h00, "R2 wrap 59 to 00", sec_bcd, 8'h00);
   endtask

   // R10, R11
   task automatic t_scan();
      int prev = -1;
      for (int i = 0; i < 20; i++) begin
         int pos = -1;
         int zeros = 0;
         logic [6:0] want;
         @(negedge clk);
         for (int b = 0; b < 8; b++) if (!dig_n[b]) begin zeros++; pos = b; end
         chk(zeros == 1, "R10 one digit low", zeros, 1);
         if (prev >= 0 && pos != prev)
            chk(pos == (prev + 1) % 8, "R10 scan order", pos, (prev + 1) % 8);
         prev = pos;
         case (pos)
            0: want = exp_seg(hr_bcd[7:4]);
            1: want = exp_seg(hr_bcd[3:0]);
            3: want = exp_seg(min_bcd[7:4]);
            4: want = exp_seg(min_bcd[3:0]);
            6: want = exp_seg(sec_bcd[7:4]);
            7: want = exp_seg(sec_bcd[3:0]);
            default: want = 7'b1000000;
         endcase
         chk(seg == want, "R11 segment code", seg, want);
      end
   endtask

   // R7
   task automatic t_sec_clear();
      sec_key_n = 1'b0;
      cyc(120);
      chk(sec_bcd == 8'h00, "R7 held clear", sec_bcd, 8'h00);
      sec_key_n = 1'b1;
      cyc(100);
      chk(sec_bcd != 8'h00, "R7 resume after release", sec_bcd, 8'h02);
   endtask

   // R8
   task automatic t_glitch();
      logic [7:0] h0 = hr_bcd;
      hr_key_n = 1'b0;
      cyc(2);
      hr_key_n = 1'b1;
      cyc(80);
      chk(hr_bcd == h0, "R8 single-sample glitch ignored", hr_bcd, h0);
   endtask

   // R9
   task automatic t_enable();
      logic [7:0] h0 = hr_bcd;
      key_en = 1'b0;
      hr_key_n = 1'b0;
      cyc(200);
      chk(hr_bcd == h0, "R9 keys disabled", hr_bcd, h0);
      hr_key_n = 1'b1;
      cyc(10);
      key_en = 1'b1;
   endtask

   // R5
   task automatic t_hr_set();
      logic [7:0] m0;
      clear_sec();
      m0 = min_bcd;
      hold_until(0, 8'h23, "R5 hour advance");
      chk(min_bcd == m0, "R5 minutes untouched", min_bcd, m0);
   endtask

   // R6
   task automatic t_min_wrap();
      clear_sec();
      hold_until(1, 8'h59, "R6 minute advance");
      hold_until(1, 8'h00, "R6 minute wrap");
      chk(hr_bcd == 8'h23, "R6 no carry to hours", hr_bcd, 8'h23);
   endtask

   // R5
   task automatic t_hr_wrap();
      clear_sec();
      hold_until(0, 8'h00, "R5 hour wrap");
      chk(min_bcd == 8'h00, "R5 minutes untouched on wrap", min_bcd, 8'h00);
   endtask

   // R4
   task automatic t_day_wrap();
      hold_until(0, 8'h23, "R4 set hours");
      hold_until(1, 8'h59, "R4 set minutes");
      clear_sec();
      for (int i = 0; i < 3000 && sec_bcd != 8'h59; i++) @(negedge clk);
      chk(hr_bcd == 8'h23 && min_bcd == 8'h59, "R4 at 23:59:59",
          {hr_bcd, min_bcd}, 16'h2359);
      for (int i = 0; i < 100 && sec_bcd == 8'h59; i++) @(negedge clk);
      chk({hr_bcd, min_bcd, sec_bcd} == 24'h000000, "R4 day rollover",
          {hr_bcd, min_bcd, sec_bcd}, 0);
   endtask

   initial begin
      cyc(1);
      t_reset();
      t_count();
      t_scan();
      t_sec_clear();
      t_glitch();
      t_enable();
      t_hr_set();
      t_min_wrap();
      t_hr_wrap();
      t_day_wrap();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule